// File: doc/BRIEF.md
# Interrupt Entry and Register-Bank Switch Controller

This block accepts interrupts for a small 32-bit RISC coprocessor. Six request lines feed edge-detecting latches. A latched request is serviced when its enable bit in the flags register is set and the global interrupt mask is clear. If several requests qualify, the one with the highest source index wins.

Acceptance sets the mask, and the mask forces register bank 0 to be the active bank. The block then runs a fixed entry sequence, in this order:
- It decrements the stack register (r31) by 4.
- It writes the return address (current PC minus 2) into the link register (r30).
- It pushes the same word to memory at the new stack address.
- In the following cycle, it loads the program counter with a vector computed from the source index.

Software reads and writes the flags register through a simple port. A write can clear the mask but can never set it. Clearing the mask makes the block look again at the pending latches, so a request that was held back is taken at once.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After synchronous reset, the flags read value is 0, no request is pending, the active bank is 0, and the stack, link, memory and PC-load strobes are all 0.
- R2: A flags read returns the stored word ANDed with 0xFFFFC1FF. Bit 0 is zero, bit 1 is carry, bit 2 is negative, bit 3 is the interrupt mask, bit 14 selects the register bank, and bits 16+k enable source k.
- R3: A software write stores its data with bit 3 forced to 0. A write never sets the mask, and a write with bit 3 at 0 clears it.
- R4: A rising edge on request line k sets pending bit k. The pending bit stays set until that source is accepted, and acceptance clears it.
- R5: An interrupt is taken only when a pending bit and its enable bit are both set and the mask is clear. A new edge counts in the cycle it arrives. Among qualifying sources, the highest index is taken.
- R6: Acceptance sets the mask in the same clock edge. While the mask is set, the active-bank output is 0, whatever bit 14 holds.
- R7: One cycle after acceptance, the stack write strobe carries `sp_i - 4` and the link write strobe carries the PC presented at acceptance minus 2.
- R8: The memory write strobe is high for exactly one cycle, in the same cycle as the register strobes. Its address equals the new stack value and its data equals the link value.
- R9: In the cycle after the push, the PC-load strobe is high for one cycle with PC = 0x0000_1000 + 16 * source index.
- R10: When the mask is cleared by software, a request that is still pending and enabled is taken without any new edge.
- R11: When a software write and an acceptance fall on the same edge, the written bits are stored and the mask ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 6 | Interrupt request lines, one per source |
| flg_wr_i | input | 1 | Flags register write strobe |
| flg_wdata_i | input | 32 | Flags register write data |
| flg_rdata_o | output | 32 | Flags register read value |
| pend_o | output | 6 | Pending request latches |
| bank_o | output | 1 | Active register bank |
| cur_pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | r31 of the active bank |
| sp_we_o | output | 1 | r31 write strobe |
| sp_wdata_o | output | 32 | r31 write value |
| link_we_o | output | 1 | r30 write strobe |
| link_wdata_o | output | 32 | r30 write value |
| mem_we_o | output | 1 | Memory push strobe |
| mem_addr_o | output | 32 | Memory push address |
| mem_wdata_o | output | 32 | Memory push data |
| pc_load_o | output | 1 | PC load strobe |
| pc_o | output | 32 | New PC value |

## Verification
A software write to the flags register and the acceptance of an interrupt can land on the same clock edge. The bench provokes this by presenting a write strobe in the same cycle as a fresh request edge on an already-enabled source. It then checks three things: the stored flags match the written word, the mask reads back as set, and the entry sequence still runs. Two related collisions are also exercised. One is a request edge arriving while the mask is set. The other is the mask being cleared while a request is pending; here the entry is expected to start one edge after the write, with no new request edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_PUSH = 2'd2,
    ST_JUMP = 2'd3
  } entry_st_t;
endpackage

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_eff_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] irq_q;
  logic [N-1:0] pend_q;

  for (genvar k = 0; k < N; k++) begin : g_src
    logic rise;
    assign rise          = irq_i[k] & ~irq_q[k];
    assign pend_eff_o[k] = pend_q[k] | rise;
    always_ff @(posedge clk) begin
      if (rst) begin
        irq_q[k]  <= 1'b0;
        pend_q[k] <= 1'b0;
      end else begin
        irq_q[k]  <= irq_i[k];
        pend_q[k] <= pend_eff_o[k] & ~clr_i[k];
      end
    end
    // R4: a rising request edge not accepted this cycle leaves the latch set
    a_r4_edge_latched: assert property (@(posedge clk) disable iff (rst)
      (irq_i[k] && !irq_q[k] && !clr_i[k]) |=> pend_q[k]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_pkg::*;
#(
  parameter int          W         = 32,
  parameter int          IW        = 3,
  parameter logic [W-1:0] VEC_BASE = 32'h0000_1000,
  parameter int          VEC_SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_i,
  input  logic [IW-1:0] src_i,
  input  logic [W-1:0]  cur_pc_i,
  input  logic [W-1:0]  sp_i,
  output logic          idle_o,
  output logic          sp_we_o,
  output logic [W-1:0]  sp_wdata_o,
  output logic          link_we_o,
  output logic [W-1:0]  link_wdata_o,
  output logic          mem_we_o,
  output logic [W-1:0]  mem_addr_o,
  output logic [W-1:0]  mem_wdata_o,
  output logic          pc_load_o,
  output logic [W-1:0]  pc_o
);
  localparam logic [W-1:0] SLOT = W'(4);
  localparam logic [W-1:0] HALF = W'(2);

  entry_st_t    st;
  logic [W-1:0] ret_q;
  logic [IW-1:0] src_q;

  assign idle_o = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      ret_q        <= '0;
      src_q        <= '0;
      sp_we_o      <= 1'b0;
      sp_wdata_o   <= '0;
      link_we_o    <= 1'b0;
      link_wdata_o <= '0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
      pc_load_o    <= 1'b0;
      pc_o         <= '0;
    end else begin
      case (st)
        ST_IDLE: if (take_i) begin
          ret_q <= cur_pc_i - HALF;
          src_q <= src_i;
          st    <= ST_SAVE;
        end
        ST_SAVE: begin
          sp_we_o      <= 1'b1;
          sp_wdata_o   <= sp_i - SLOT;
          link_we_o    <= 1'b1;
          link_wdata_o <= ret_q;
          mem_we_o     <= 1'b1;
          mem_addr_o   <= sp_i - SLOT;
          mem_wdata_o  <= ret_q;
          st           <= ST_PUSH;
        end
        ST_PUSH: begin
          sp_we_o   <= 1'b0;
          link_we_o <= 1'b0;
          mem_we_o  <= 1'b0;
          pc_load_o <= 1'b1;
          pc_o      <= VEC_BASE + (W'(src_q) << VEC_SHIFT);
          st        <= ST_JUMP;
        end
        default: begin
          pc_load_o <= 1'b0;
          st        <= ST_IDLE;
        end
      endcase
    end
  end

  // R8: the push strobe lasts a single cycle
  a_r8_push_single: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> !mem_we_o);
  // R9: the PC load follows the push in the next cycle
  a_r9_load_after_push: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> pc_load_o);
  // R7: register strobes coincide with the push, same address and word
  a_r7_regs_with_push: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (sp_we_o && link_we_o && mem_addr_o == sp_wdata_o
                  && mem_wdata_o == link_wdata_o));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int           NSRC      = 6,
  parameter int           W         = 32,
  parameter logic [31:0]  VEC_BASE  = 32'h0000_1000,
  parameter int           VEC_SHIFT = 4,
  parameter int           MASK_BIT  = 3,
  parameter int           BANK_BIT  = 14,
  parameter int           EN_LSB    = 16,
  parameter logic [31:0]  RD_MASK   = 32'hFFFF_C1FF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_i,
  input  logic            flg_wr_i,
  input  logic [W-1:0]    flg_wdata_i,
  output logic [W-1:0]    flg_rdata_o,
  output logic [NSRC-1:0] pend_o,
  output logic            bank_o,
  input  logic [W-1:0]    cur_pc_i,
  input  logic [W-1:0]    sp_i,
  output logic            sp_we_o,
  output logic [W-1:0]    sp_wdata_o,
  output logic            link_we_o,
  output logic [W-1:0]    link_wdata_o,
  output logic            mem_we_o,
  output logic [W-1:0]    mem_addr_o,
  output logic [W-1:0]    mem_wdata_o,
  output logic            pc_load_o,
  output logic [W-1:0]    pc_o
);
  localparam int           IW    = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [W-1:0] MBIT  = W'(1) << MASK_BIT;

  logic [W-1:0]    flags_q;
  logic [NSRC-1:0] pend_eff, clr, cand;
  logic            any, take, idle, mask;
  logic [IW-1:0]   src;

  assign mask = flags_q[MASK_BIT];
  assign cand = pend_eff & flags_q[EN_LSB +: NSRC];
  assign take = idle & ~mask & any;

  for (genvar k = 0; k < NSRC; k++) begin : g_clr
    assign clr[k] = take && (src == IW'(k));
  end

  irq_latch #(.N(NSRC)) latch_i (
    .clk(clk), .rst(rst), .irq_i(irq_i), .clr_i(clr),
    .pend_eff_o(pend_eff), .pend_o(pend_o)
  );

  irq_prio #(.N(NSRC), .IW(IW)) prio_i (
    .req_i(cand), .any_o(any), .idx_o(src)
  );

  irq_entry_fsm #(.W(W), .IW(IW), .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)) fsm_i (
    .clk(clk), .rst(rst), .take_i(take), .src_i(src),
    .cur_pc_i(cur_pc_i), .sp_i(sp_i), .idle_o(idle),
    .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o),
    .link_we_o(link_we_o), .link_wdata_o(link_wdata_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .pc_load_o(pc_load_o), .pc_o(pc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (take) begin
      flags_q <= (flg_wr_i ? (flg_wdata_i & ~MBIT) : flags_q) | MBIT;
    end else if (flg_wr_i) begin
      flags_q <= flg_wdata_i & ~MBIT;
    end
  end

  assign flg_rdata_o = flags_q & RD_MASK;
  assign bank_o      = mask ? 1'b0 : flags_q[BANK_BIT];

  // R3: software alone never sets the mask
  a_r3_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    (flg_wr_i && !take && !mask) |=> !flags_q[MASK_BIT]);
  // R6: acceptance leaves the mask set and bank 0 active
  a_r6_entry_masks: assert property (@(posedge clk) disable iff (rst)
    take |=> (flags_q[MASK_BIT] && !bank_o));
  // R5: a taken source was enabled and latched
  a_r5_taken_enabled: assert property (@(posedge clk) disable iff (rst)
    take |-> (flags_q[EN_LSB + int'(src)] && pend_eff[src]));
  // R5: no entry starts while masked
  a_r5_masked_hold: assert property (@(posedge clk) disable iff (rst)
    (idle && mask && !flg_wr_i) |=> idle);
endmodule

// File: tb/irq_entry_ctrl_tb_top.sv
module irq_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  irq_i;
  logic        flg_wr_i;
  logic [31:0] flg_wdata_i, flg_rdata_o, cur_pc_i, sp_i;
  logic [5:0]  pend_o;
  logic        bank_o, sp_we_o, link_we_o, mem_we_o, pc_load_o;
  logic [31:0] sp_wdata_o, link_wdata_o, mem_addr_o, mem_wdata_o, pc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_entry_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_i(irq_i), .flg_wr_i(flg_wr_i),
    .flg_wdata_i(flg_wdata_i), .flg_rdata_o(flg_rdata_o), .pend_o(pend_o),
    .bank_o(bank_o), .cur_pc_i(cur_pc_i), .sp_i(sp_i),
    .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o),
    .link_we_o(link_we_o), .link_wdata_o(link_wdata_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .pc_load_o(pc_load_o), .pc_o(pc_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic int top_idx(input logic [5:0] v);
    int r = -1;
    for (int k = 0; k < 6; k++) if (v[k]) r = k;
    return r;
  endfunction

  function automatic logic [31:0] vec_of(input int k);
    return 32'h0000_1000 + 32'(k) * 32'd16;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_i = '0; flg_wr_i = 1'b0; flg_wdata_i = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_flags(input logic [31:0] d);
    @(negedge clk);
    flg_wr_i = 1'b1; flg_wdata_i = d;
    @(negedge clk);
    flg_wr_i = 1'b0;
  endtask

  // After acceptance edge: check entry sequence for source k
  task automatic chk_entry(input int k, input logic [31:0] pcv, input logic [31:0] spv);
    chk("R6 mask set", 32'(flg_rdata_o[3]), 32'd1);
    chk("R6 bank 0", 32'(bank_o), 32'd0);
    chk("R7 no strobe yet", 32'(mem_we_o), 32'd0);
    @(negedge clk);
    chk("R7 sp we", 32'(sp_we_o), 32'd1);
    chk("R7 sp data", sp_wdata_o, spv - 32'd4);
    chk("R7 link data", link_wdata_o, pcv - 32'd2);
    chk("R8 mem we", 32'(mem_we_o), 32'd1);
    chk("R8 mem addr", mem_addr_o, spv - 32'd4);
    chk("R8 mem data", mem_wdata_o, pcv - 32'd2);
    chk("R9 no load yet", 32'(pc_load_o), 32'd0);
    @(negedge clk);
    chk("R8 push one cycle", 32'(mem_we_o), 32'd0);
    chk("R9 pc load", 32'(pc_load_o), 32'd1);
    chk("R9 vector", pc_o, vec_of(k));
    @(negedge clk);
    chk("R9 load one cycle", 32'(pc_load_o), 32'd0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    rst = 1'b1; irq_i = '0; flg_wr_i = 1'b0; flg_wdata_i = '0;
    cur_pc_i = 32'h0000_2346; sp_i = 32'h0000_8000;
    do_reset();
    @(negedge clk);
    chk("R1 flags", flg_rdata_o, 32'd0);
    chk("R1 pend", 32'(pend_o), 32'd0);
    chk("R1 bank", 32'(bank_o), 32'd0);
    chk("R1 strobes", {28'd0, sp_we_o, link_we_o, mem_we_o, pc_load_o}, 32'd0);

    // R2 / R3: random writes without enables, no requests pending
    for (int i = 0; i < 20; i++) begin
      logic [31:0] d;
      d = $urandom() & 32'hFFC0_FFFF;
      if (i < 3) d[3] = 1'b1;
      wr_flags(d);
      chk("R2 R3 read mask", flg_rdata_o, d & 32'hFFFF_C1F7);
      chk("R6 bank follows bit14", 32'(bank_o), 32'(d[14]));
    end

    // R5 / R4 / R9: random pending vs enable patterns
    for (int i = 0; i < 40; i++) begin
      logic [5:0] p, e;
      int k;
      p = 6'($urandom()); e = 6'($urandom());
      if (i == 0) begin p = 6'h3F; e = 6'h3F; end
      if (i == 1) begin p = 6'h21; e = 6'h01; end
      if (i == 2) begin p = 6'h0C; e = 6'h30; end
      do_reset();
      wr_flags({10'd0, e, 16'h4000});
      cur_pc_i = 32'h0000_3000 + 32'(i) * 32'd8;
      sp_i = 32'h0000_9000 - 32'(i) * 32'd16;
      @(negedge clk); irq_i = p;
      @(negedge clk); irq_i = '0;
      k = top_idx(p & e);
      if (k < 0) begin
        chk("R5 none taken", 32'(flg_rdata_o[3]), 32'd0);
        chk("R4 pend kept", 32'(pend_o), 32'(p));
        @(negedge clk);
        chk("R5 no push", 32'(mem_we_o), 32'd0);
      end else begin
        chk("R4 R5 pend cleared for taken", 32'(pend_o), 32'(p & ~(6'd1 << k)));
        chk_entry(k, cur_pc_i, sp_i);
      end
    end

    // R10: request while masked waits; clearing the mask takes it
    do_reset();
    wr_flags(32'h0024_0000);                  // enable sources 2 and 5
    @(negedge clk); irq_i = 6'h20;
    @(negedge clk); irq_i = '0;
    chk_entry(5, cur_pc_i, sp_i);
    @(negedge clk); irq_i = 6'h04;
    @(negedge clk); irq_i = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R5 R10 held while masked", 32'(mem_we_o), 32'd0);
    end
    chk("R4 R10 pending held", 32'(pend_o), 32'h04);
    cur_pc_i = 32'h0000_5552;
    wr_flags(32'h0024_0000);                  // after write edge: mask cleared
    @(negedge clk);                           // after take edge
    chk("R10 pend cleared", 32'(pend_o), 32'd0);
    chk_entry(2, 32'h0000_5552, sp_i);

    // R11: software write on the acceptance edge
    do_reset();
    wr_flags(32'h0001_0000);                  // enable source 0
    @(negedge clk);
    irq_i = 6'h01; flg_wr_i = 1'b1; flg_wdata_i = 32'h0001_4006;
    @(negedge clk);
    irq_i = '0; flg_wr_i = 1'b0;
    chk("R11 written bits kept with mask", flg_rdata_o, 32'h0001_400E);
    chk_entry(0, cur_pc_i, sp_i);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule